// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block takes 53-byte ATM cells from a byte-wide write port, holds them in a small store of whole cells, and sends them as a serial bit stream toward a T1/E1 framer. A start-of-cell strobe marks the first byte of each written cell. A cell is sent only once all 53 of its bytes are stored. When no complete cell is waiting at a cell boundary, the block makes an idle cell itself, so the line never runs dry.

On the way out, two optional stages act on each cell. The fifth header byte can be replaced by a header check value: an 8-bit CRC of the first four header bytes, with a programmable coset value XORed into it. The 48 payload bytes can be scrambled by a self-synchronizing x^43+1 scrambler whose state carries from one cell to the next. The framer sets the pace with a per-bit enable. One bit leaves for each enabled cycle, so fractional use of the line needs nothing more than gaps in that enable.

The store has four physical cell slots. A depth setting limits how many of them may be filled, and the space indication follows that limit. Writes that arrive while the store is full are dropped and set a sticky overflow flag.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: After synchronous reset, ser_bit is 0, cell_space is 1, overflow is 0 and the store holds no cells.
- R2: When no complete cell is stored at the first bit of a cell, an idle cell is sent: header bytes 00 00 00 01, then the check byte (CRC of those four bytes XOR coset, 0x52 for coset 0x55, always inserted), then 48 bytes of 0x6A.
- R3: Each cell is sent byte 0 first, each byte most-significant bit first. ser_bit changes only on a clock edge where bit_en is 1 and holds its value while bit_en is 0.
- R4: With hec_en = 1, byte 4 of a user cell is replaced by CRC-8 (polynomial x^8+x^2+x+1, initial value 0, MSB first) of bytes 0 to 3, XOR coset. With hec_en = 0, the written byte 4 is sent unchanged.
- R5: With scr_en = 1, each payload bit (bytes 5 to 52) is sent as data XOR the output bit sent 43 payload bits earlier. The scrambler state starts at zero after reset, advances only on scrambled payload bits and carries across cells. Header bytes are never scrambled. With scr_en = 0, payload bytes are sent as written.
- R6: cfg_depth sets the usable depth: values below 2 act as 2 and values above 4 act as 4. cell_space is 1 exactly when fewer complete cells than the usable depth are stored.
- R7: A write while the stored complete cells equal the usable depth is ignored, and overflow becomes 1 and stays 1 until reset.
- R8: A partly written cell is never sent. An idle cell goes out in its place.
- R9: Complete cells leave in the order they were written.
- R10: A write with wr_sop = 1 stores its byte as byte 0 of the cell being filled and discards any partial cell written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cell byte |
| wr_sop | input | 1 | Marks the written byte as byte 0 of a cell |
| wr_data | input | 8 | Cell byte to store |
| cfg_depth | input | 3 | Usable store depth in cells (2 to 4) |
| hec_en | input | 1 | Replace byte 4 with the computed check value |
| scr_en | input | 1 | Scramble payload bytes |
| coset | input | 8 | Value XORed into the computed check byte |
| bit_en | input | 1 | Framer request for the next serial bit |
| ser_bit | output | 1 | Serial cell stream, registered |
| cell_space | output | 1 | Room for another complete cell |
| overflow | output | 1 | Sticky: a write was dropped because the store was full |

## Verification
The bound checker watches every cycle for the following. The serial output must hold while the enable is low. The overflow flag must never clear. The fill level must not rise while a write meets a full store, and it must never pass the slot count. The space indication must match the fill level against the clipped depth. A cell must never leave while no complete cell is stored. Only the bench scenarios can show that the bytes on the line are right. These cover the check byte and coset values, pass-through with the check disabled, scrambler continuity across user and idle cells, cell order, the drop of a third cell at depth 2, the idle cell in place of a partial one, and the restart on a start-of-cell strobe.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam logic [7:0] HEC_POLY = 8'h07;

  // One byte of CRC-8 update, MSB first, polynomial x^8+x^2+x+1
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/atm_cell_fifo.sv
module atm_cell_fifo #(
  parameter int unsigned MAX_CELLS = 4,
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned CNT_W = $clog2(MAX_CELLS + 1),
  localparam int unsigned IDX_W = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_depth,
  input  logic             wr_en,
  input  logic             wr_sop,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             pop,
  output logic             empty,
  output logic [CNT_W-1:0] level,
  output logic             space,
  output logic             overflow
);
  localparam int unsigned SLOT_W = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
  localparam int unsigned DEPTH  = MAX_CELLS * CELL_BYTES;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  wr_idx, cur_idx;
  logic [CNT_W-1:0]  cnt, cnt_next, depth_eff;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              full, accept, cell_done;

  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(MAX_CELLS - 1)) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    if (cfg_depth < CNT_W'(2))              depth_eff = CNT_W'(2);
    else if (cfg_depth > CNT_W'(MAX_CELLS)) depth_eff = CNT_W'(MAX_CELLS);
    else                                    depth_eff = cfg_depth;
  end

  assign full      = (cnt >= depth_eff);
  assign accept    = wr_en & ~full;
  assign cur_idx   = wr_sop ? '0 : wr_idx;
  assign cell_done = accept & (cur_idx == IDX_W'(CELL_BYTES - 1));
  assign wr_addr   = ADDR_W'(wr_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(cur_idx);
  assign rd_addr   = ADDR_W'(rd_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);

  always_comb begin
    cnt_next = cnt;
    if (cell_done && !pop)      cnt_next = cnt + 1'b1;
    else if (!cell_done && pop) cnt_next = cnt - 1'b1;
  end

  // Plain write port, asynchronous read: maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (accept) mem[wr_addr] <= wr_data;
  end
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot  <= '0;
      rd_slot  <= '0;
      wr_idx   <= '0;
      cnt      <= '0;
      space    <= 1'b1;
      overflow <= 1'b0;
    end else begin
      cnt   <= cnt_next;
      space <= (cnt_next < depth_eff);
      if (wr_en && full) overflow <= 1'b1;
      if (accept) begin
        if (cell_done) begin
          wr_idx  <= '0;
          wr_slot <= slot_inc(wr_slot);
        end else begin
          wr_idx <= cur_idx + 1'b1;
        end
      end
      if (pop) rd_slot <= slot_inc(rd_slot);
    end
  end

  assign empty = (cnt == '0);
  assign level = cnt;
endmodule

// File: rtl/atm_hec_accum.sv
module atm_hec_accum
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       clear,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clear) crc <= '0;
    else if (step)    crc <= crc8_step(crc, din);
  end
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler #(
  parameter int unsigned SCR_LEN = 43
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_LEN-1:0] hist, hist_nx;

  // Eight serial steps, MSB first: each output bit feeds back into the history
  always_comb begin
    hist_nx = hist;
    for (int i = 7; i >= 0; i--) begin
      dout[i] = din[i] ^ hist_nx[SCR_LEN-1];
      hist_nx = {hist_nx[SCR_LEN-2:0], dout[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       hist <= '0;
    else if (step) hist <= hist_nx;
  end
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc #(
  parameter int unsigned MAX_CELLS  = 4,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned HDR_BYTES  = 5,
  parameter int unsigned SCR_LEN    = 43,
  parameter logic [31:0] IDLE_HDR   = 32'h0000_0001,
  parameter logic [7:0]  IDLE_FILL  = 8'h6A,
  localparam int unsigned CNT_W = $clog2(MAX_CELLS + 1),
  localparam int unsigned IDX_W = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sop,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] cfg_depth,
  input  logic             hec_en,
  input  logic             scr_en,
  input  logic [7:0]       coset,
  input  logic             bit_en,
  output logic             ser_bit,
  output logic             cell_space,
  output logic             overflow
);
  localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] bidx_q;
  logic [2:0]       bitc_q;
  logic             idle_q, idle_now, at_start, byte_end;
  logic             fifo_empty, fifo_pop;
  logic [CNT_W-1:0] fifo_level;
  logic [7:0]       fifo_rd, raw_byte, idle_byte, tx_byte, crc_q, scr_out;
  logic [1:0]       hsel;
  logic             is_hdr, is_hec, is_pay;

  atm_cell_fifo #(.MAX_CELLS(MAX_CELLS), .CELL_BYTES(CELL_BYTES)) u_fifo (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
    .wr_en(wr_en), .wr_sop(wr_sop), .wr_data(wr_data),
    .rd_idx(bidx_q), .rd_data(fifo_rd), .pop(fifo_pop),
    .empty(fifo_empty), .level(fifo_level),
    .space(cell_space), .overflow(overflow)
  );

  assign at_start = (bidx_q == '0) && (bitc_q == 3'd0);
  assign idle_now = at_start ? fifo_empty : idle_q;
  assign byte_end = bit_en && (bitc_q == 3'd7);
  assign is_hdr   = (bidx_q < HEC_IDX);
  assign is_hec   = (bidx_q == HEC_IDX);
  assign is_pay   = (bidx_q > HEC_IDX);
  assign fifo_pop = byte_end && (bidx_q == LAST_IDX) && !idle_now;

  atm_hec_accum u_hec (
    .clk(clk), .rst(rst),
    .step(byte_end && is_hdr),
    .clear(byte_end && (bidx_q == LAST_IDX)),
    .din(tx_byte), .crc(crc_q)
  );

  atm_payload_scrambler #(.SCR_LEN(SCR_LEN)) u_scr (
    .clk(clk), .rst(rst),
    .step(byte_end && is_pay && scr_en),
    .din(raw_byte), .dout(scr_out)
  );

  assign hsel = 2'd3 - bidx_q[1:0];

  always_comb begin
    if (is_hdr)      idle_byte = IDLE_HDR[{hsel, 3'b000} +: 8];
    else if (is_hec) idle_byte = 8'h00;
    else             idle_byte = IDLE_FILL;
    raw_byte = idle_now ? idle_byte : fifo_rd;
    if (is_hec)                tx_byte = (hec_en || idle_now) ? (crc_q ^ coset) : raw_byte;
    else if (is_pay && scr_en) tx_byte = scr_out;
    else                       tx_byte = raw_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bidx_q  <= '0;
      bitc_q  <= '0;
      idle_q  <= 1'b1;
      ser_bit <= 1'b0;
    end else if (bit_en) begin
      ser_bit <= tx_byte[3'd7 - bitc_q];
      bitc_q  <= bitc_q + 3'd1;
      if (at_start) idle_q <= fifo_empty;
      if (bitc_q == 3'd7) bidx_q <= (bidx_q == LAST_IDX) ? '0 : bidx_q + 1'b1;
    end
  end
endmodule

// File: rtl/atm_tx_checker.sv
module atm_tx_checker #(
  parameter int unsigned MAX_CELLS = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             ser_bit,
  input logic             wr_en,
  input logic [CNT_W-1:0] cfg_depth,
  input logic [CNT_W-1:0] level,
  input logic             cell_space,
  input logic             overflow,
  input logic             pop
);
  logic [CNT_W-1:0] cfg_d, eff_d, eff_now;

  function automatic logic [CNT_W-1:0] clip(input logic [CNT_W-1:0] v);
    if (v < CNT_W'(2)) return CNT_W'(2);
    if (v > CNT_W'(MAX_CELLS)) return CNT_W'(MAX_CELLS);
    return v;
  endfunction

  always_ff @(posedge clk) cfg_d <= cfg_depth;
  assign eff_d   = clip(cfg_d);
  assign eff_now = clip(cfg_depth);

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(ser_bit)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (wr_en && level >= eff_now) |=> level <= $past(level)); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst) level <= CNT_W'(MAX_CELLS)); // R6
  AST_SPACE_MATCH: assert property (@(posedge clk) disable iff (rst) cell_space == (level < eff_d)); // R6
  AST_POP_WHOLE: assert property (@(posedge clk) disable iff (rst) pop |-> level != '0); // R8
endmodule

bind atm_tx_cell_proc atm_tx_checker #(.MAX_CELLS(MAX_CELLS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .ser_bit(ser_bit), .wr_en(wr_en),
  .cfg_depth(cfg_depth), .level(fifo_level), .cell_space(cell_space),
  .overflow(overflow), .pop(fifo_pop)
);

// File: tb/sim_atm_tx_cell_proc.sv
module sim_atm_tx_cell_proc;
  localparam int CLK_P = 10;
  typedef logic [7:0] cell_t [53];

  logic clk = 0, rst = 1, wr_en = 0, wr_sop = 0, hec_en = 1, scr_en = 0, bit_en = 0;
  logic [7:0] wr_data = 0, coset = 8'h55;
  logic [2:0] cfg_depth = 3'd4;
  logic ser_bit, cell_space, overflow;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [42:0] m_hist = '0;

  // {hdr[31:0], byte4, coset, seed, 6'b0, hec_en, scr_en}
  localparam logic [63:0] VEC [6] = '{
    64'h12345678_AA_55_01_02, 64'h00000000_FF_55_80_00, 64'hFFFFFFFF_00_00_33_03,
    64'h0A0B0C0D_5A_C3_F0_03, 64'h80000001_11_55_07_01, 64'hDEADBEEF_22_55_6A_02 };

  always #(CLK_P/2) clk = ~clk;

  atm_tx_cell_proc u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sop(wr_sop), .wr_data(wr_data),
    .cfg_depth(cfg_depth), .hec_en(hec_en), .scr_en(scr_en), .coset(coset), .bit_en(bit_en),
    .ser_bit(ser_bit), .cell_space(cell_space), .overflow(overflow));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_cell(input string tag, input cell_t got, input cell_t exp);
    int bad;
    bad = -1;
    for (int i = 52; i >= 0; i--) if (got[i] !== exp[i]) bad = i;
    n_vec++;
    if (bad >= 0) begin
      n_bad++;
      $display("FAIL %s byte %0d got=%0h exp=%0h", tag, bad, got[bad], exp[bad]);
    end
  endtask

  task automatic mk_cell(input logic [31:0] hdr, input logic [7:0] b4, input logic [7:0] seed,
                         output cell_t c);
    for (int i = 0; i < 4; i++) c[i] = hdr[8*(3-i) +: 8];
    c[4] = b4;
    for (int i = 5; i < 53; i++) c[i] = seed + 8'(i * 13);
  endtask

  // Expected line bytes, built from the requirements
  task automatic build_exp(input cell_t src, input bit idle, output cell_t e);
    logic [7:0] crc;
    logic fb, o;
    e = src;
    if (idle) begin
      e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h01; e[4] = 8'h00;
      for (int i = 5; i < 53; i++) e[i] = 8'h6A;
    end
    if (hec_en || idle) begin
      crc = 8'h00;
      for (int i = 0; i < 4; i++)
        for (int k = 7; k >= 0; k--) begin
          fb  = crc[7] ^ e[i][k];
          crc = {crc[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
      e[4] = crc ^ coset;
    end
    if (scr_en)
      for (int i = 5; i < 53; i++)
        for (int k = 7; k >= 0; k--) begin
          o = e[i][k] ^ m_hist[42];
          e[i][k] = o;
          m_hist = {m_hist[41:0], o};
        end
  endtask

  task automatic write_cell(input cell_t c, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      wr_en = 1; wr_sop = (i == 0); wr_data = c[i];
    end
    @(negedge clk);
    wr_en = 0; wr_sop = 0;
  endtask

  task automatic rx_cell(input int gap, output cell_t c, output bit stable_ok);
    stable_ok = 1;
    for (int b = 0; b < 53; b++)
      for (int k = 7; k >= 0; k--) begin
        @(negedge clk) bit_en = 1;
        @(negedge clk) bit_en = 0;
        c[b][k] = ser_bit;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (ser_bit !== c[b][k]) stable_ok = 0;
        end
      end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired (all requirements) got=running exp=done");
    finish_run();
  end

  initial begin
    cell_t c, d, e, got, exp;
    bit st;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ser_bit after reset", ser_bit, 0);
    chk("R1 cell_space after reset", cell_space, 1);
    chk("R1 overflow after reset", overflow, 0);

    // Idle cell on an empty store, with gaps in the bit enable
    mk_cell(32'h0, 8'h0, 8'h0, d);
    rx_cell(1, got, st);
    build_exp(d, 1, exp);
    chk_cell("R2 idle cell", got, exp);
    chk("R2 idle check byte", got[4], 8'h52);
    chk("R3 output holds while bit_en low", st, 1);

    // Vector table: R4 check byte, R5 scrambling, R9 one cell per slot
    foreach (VEC[v]) begin
      hec_en = VEC[v][1]; scr_en = VEC[v][0]; coset = VEC[v][23:16];
      mk_cell(VEC[v][63:32], VEC[v][31:24], VEC[v][15:8], c);
      write_cell(c, 53);
      rx_cell(v % 2, got, st);
      build_exp(c, 0, exp);
      chk_cell($sformatf("R4/R5 vector %0d", v), got, exp);
    end

    // Idle cell with scrambling on: header untouched, payload scrambled (R5)
    hec_en = 1; coset = 8'h55; scr_en = 1;
    rx_cell(0, got, st);
    build_exp(d, 1, exp);
    chk_cell("R5 scrambled idle cell", got, exp);
    chk("R5 header not scrambled", {got[0], got[1], got[2], got[3]}, 32'h1);

    // Depth 2: third cell dropped, overflow sticky, order kept
    scr_en = 0; cfg_depth = 3'd2;
    mk_cell(32'hA1A2A3A4, 8'h0, 8'h10, c);
    mk_cell(32'hB1B2B3B4, 8'h0, 8'h20, d);
    mk_cell(32'hC1C2C3C4, 8'h0, 8'h30, e);
    write_cell(c, 53);
    chk("R6 space at depth 2 with 1 cell", cell_space, 1);
    write_cell(d, 53);
    chk("R6 space at depth 2 with 2 cells", cell_space, 0);
    chk("R7 overflow before drop", overflow, 0);
    write_cell(e, 53);
    chk("R7 overflow after write to full store", overflow, 1);
    rx_cell(0, got, st); build_exp(c, 0, exp); chk_cell("R9 first cell out", got, exp);
    rx_cell(0, got, st); build_exp(d, 0, exp); chk_cell("R9 second cell out", got, exp);
    rx_cell(0, got, st); build_exp(e, 1, exp); chk_cell("R7 dropped cell not sent", got, exp);
    chk("R7 overflow stays set", overflow, 1);

    // Depth 3 and clipped depth code 7 (acts as 4)
    cfg_depth = 3'd3;
    write_cell(c, 53); write_cell(d, 53);
    chk("R6 space at depth 3 with 2 cells", cell_space, 1);
    write_cell(e, 53);
    chk("R6 space at depth 3 with 3 cells", cell_space, 0);
    rx_cell(0, got, st); build_exp(c, 0, exp); chk_cell("R9 depth 3 cell 1", got, exp);
    rx_cell(0, got, st); build_exp(d, 0, exp); chk_cell("R9 depth 3 cell 2", got, exp);
    rx_cell(0, got, st); build_exp(e, 0, exp); chk_cell("R9 depth 3 cell 3", got, exp);
    cfg_depth = 3'd7;
    write_cell(c, 53); write_cell(d, 53); write_cell(e, 53);
    chk("R6 space at clipped depth 4 with 3 cells", cell_space, 1);
    write_cell(c, 53);
    chk("R6 space at clipped depth 4 with 4 cells", cell_space, 0);
    for (int i = 0; i < 4; i++) begin
      rx_cell(0, got, st);
      build_exp((i == 1) ? d : (i == 2) ? e : c, 0, exp);
      chk_cell($sformatf("R9 depth 4 cell %0d", i), got, exp);
    end

    // Partial cell is held back; a start strobe restarts the cell
    cfg_depth = 3'd2;
    write_cell(e, 30);
    rx_cell(0, got, st); build_exp(e, 1, exp); chk_cell("R8 partial cell gives idle", got, exp);
    write_cell(c, 53);
    rx_cell(0, got, st); build_exp(c, 0, exp); chk_cell("R10 restart on start strobe", got, exp);
    rx_cell(0, got, st); build_exp(c, 1, exp); chk_cell("R8 store empty after restart", got, exp);

    finish_run();
  end
endmodule